// File: doc/BRIEF.md
# PLL Divider Rate Calculator

This block translates between a desired PLL output frequency and the two settings that produce it: a feedback control word and a power-of-two post-divider. The control word is a fixed-point number with seven integer bits; any further bits, up to the configured word width, are fractional.

In forward operation the caller supplies a target frequency, a ceiling frequency and the reference frequency. The block clamps the target, picks the smallest post-divider that keeps the oscillator at or above a minimum frequency (1 GHz by default), and divides the scaled target by the reference with a bit-serial divider. In reverse operation the caller supplies a control word and a post-divider exponent. The block returns the output frequency, rounded upward at two stages. Requests enter through a valid/ready handshake. Results appear on registered outputs together with a one-cycle completion pulse, and they hold until the next completion.

Top module: `pll_rate_calc`

## Requirements
- R1: The fractional bit count is PCW_W minus 7 when PCW_W exceeds 7 and zero otherwise. With PCW_W of 7, forward results are plain integer ratios and reverse results apply no fractional shift.
- R2: In forward operation (in_op = 0), a target above in_fmax_hz is replaced by in_fmax_hz before anything else is computed.
- R3: The forward post-divider exponent on out_pdiv_exp is the smallest k in 0..3 for which the clamped target times 2^k is at least FMIN_HZ, and it is 3 when no k qualifies. It is never above 3.
- R4: The forward control word is floor((clamped target << k << fractional bits) / in_ref_hz), keeping its low PCW_W bits. out_rate_hz reads 0 after a forward result.
- R5: In reverse operation (in_op = 1), the product in_ref_hz × in_pcw is shifted right by the fractional bit count, plus one if any of the dropped bits were set. out_pcw and out_pdiv_exp read 0 after a reverse result.
- R6: The reverse oscillator value is divided by 2^in_pdiv_exp with ceiling rounding and driven on out_rate_hz.
- R7: A forward request with in_ref_hz of 0 completes with out_pcw = 0 and err = 1. Every other completion leaves err = 0.
- R8: in_ready is high only when the block is idle, and a request is taken when in_valid and in_ready are both high. Each accepted request gives exactly one single-cycle done pulse. in_valid while busy is ignored.
- R9: After reset, in_ready is 1, done and err are 0, and all result outputs are 0.
- R10: Result outputs and err change only in the cycle in which done is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Request strobe |
| in_ready | output | 1 | Block is idle and will accept a request |
| in_op | input | 1 | 0 = forward (frequency to settings), 1 = reverse |
| in_target_hz | input | FREQ_W | Requested output frequency (forward) |
| in_fmax_hz | input | FREQ_W | Ceiling applied to the target (forward) |
| in_ref_hz | input | FREQ_W | Reference frequency |
| in_pcw | input | PCW_W | Control word (reverse) |
| in_pdiv_exp | input | 3 | Post-divider exponent (reverse) |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Zero reference seen on the last forward request |
| out_pcw | output | PCW_W | Computed control word |
| out_pdiv_exp | output | 3 | Chosen post-divider exponent |
| out_rate_hz | output | FREQ_W+PCW_W | Computed output frequency |

## Verification
The assertions assume that request fields matter only in the cycle in which in_valid meets in_ready. The bench therefore raises in_valid for one cycle while the block is idle. The one exception is a deliberate strobe during a busy forward division, which tests that it has no effect. Two instances run side by side: one with fractional bits and one with a 7-bit word and no fraction. Both sweep targets around each post-divider threshold, ceilings below and above the target, several references including zero, and reverse words across the full range for every exponent.

// File: rtl/pll_rate_calc_pkg.sv
package pll_rate_calc_pkg;

    // Integer part of the feedback control word
    localparam int INT_BITS = 7;
    // Width of the post-divider exponent field
    localparam int EXP_W    = 3;

    typedef enum logic [1:0] {
        CALC_IDLE = 2'd0,
        CALC_REV  = 2'd1,
        CALC_FWD  = 2'd2,
        CALC_WAIT = 2'd3
    } calc_state_e;

    function automatic int frac_bits(input int word_w);
        return (word_w > INT_BITS) ? (word_w - INT_BITS) : 0;
    endfunction

endpackage

// File: rtl/pll_pdiv_search.sv
// Picks the smallest power-of-two post-divider (1,2,4,8) that lifts the
// frequency to at least FMIN_HZ; falls back to 8.
module pll_pdiv_search
    import pll_rate_calc_pkg::*;
#(
    parameter int              FREQ_W  = 32,
    parameter longint unsigned FMIN_HZ = 64'd1_000_000_000
) (
    input  logic [FREQ_W-1:0] freq_hz,
    output logic [EXP_W-1:0]  exp_o
);
    localparam int TRIES = 4;
    localparam int CMP_W = FREQ_W + 3;

    logic [TRIES-1:0] reach;

    generate
        for (genvar k = 0; k < TRIES; k++) begin : g_try
            assign reach[k] = ({3'b000, freq_hz} << k) >= CMP_W'(FMIN_HZ);
        end
    endgenerate

    // Descending scan so the lowest qualifying factor wins.
    always_comb begin
        exp_o = EXP_W'(TRIES - 1);
        for (int k = TRIES - 1; k >= 0; k--) begin
            if (reach[k]) begin
                exp_o = EXP_W'(k);
            end
        end
    end

endmodule

// File: rtl/pll_seq_divider.sv
// Restoring divider, one quotient bit per cycle.
module pll_seq_divider #(
    parameter int NUM_W = 50,
    parameter int DEN_W = 32,
    parameter int OUT_W = 22
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [NUM_W-1:0] num,
    input  logic [DEN_W-1:0] den,
    output logic             done_o,
    output logic [OUT_W-1:0] quot_o
);
    localparam int CNT_W = (NUM_W > 1) ? $clog2(NUM_W) : 1;

    typedef struct packed {
        logic             busy;
        logic             done;
        logic [CNT_W-1:0] cnt;
        logic [DEN_W-1:0] rem;
        logic [DEN_W-1:0] den;
        logic [NUM_W-1:0] quot;
    } div_state_t;

    div_state_t q, d;
    logic [DEN_W:0] trial;
    logic           qbit;

    always_comb begin
        d     = q;
        d.done = 1'b0;
        trial = {q.rem, q.quot[NUM_W-1]};
        qbit  = 1'b0;
        if (start) begin
            d.busy = 1'b1;
            d.cnt  = CNT_W'(NUM_W - 1);
            d.rem  = '0;
            d.den  = den;
            d.quot = num;
        end else if (q.busy) begin
            if (trial >= {1'b0, q.den}) begin
                qbit  = 1'b1;
                d.rem = DEN_W'(trial - {1'b0, q.den});
            end else begin
                d.rem = trial[DEN_W-1:0];
            end
            d.quot = {q.quot[NUM_W-2:0], qbit};
            if (q.cnt == '0) begin
                d.busy = 1'b0;
                d.done = 1'b1;
            end else begin
                d.cnt = q.cnt - 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign done_o = q.done;
    assign quot_o = q.quot[OUT_W-1:0];

endmodule

// File: rtl/pll_rate_recalc.sv
// Reverse path: reference x control word, fractional round-up, then
// ceiling division by the power-of-two post-divider.
module pll_rate_recalc
    import pll_rate_calc_pkg::*;
#(
    parameter int FREQ_W = 32,
    parameter int PCW_W  = 22
) (
    input  logic [FREQ_W-1:0]       ref_hz,
    input  logic [PCW_W-1:0]        pcw,
    input  logic [EXP_W-1:0]        exp_i,
    output logic [FREQ_W+PCW_W-1:0] rate_o
);
    localparam int FRAC_W = frac_bits(PCW_W);
    localparam int RATE_W = FREQ_W + PCW_W;

    logic [RATE_W-1:0] prod;
    logic [RATE_W-1:0] vco;
    logic [RATE_W:0]   biased;

    assign prod = {{PCW_W{1'b0}}, ref_hz} * {{FREQ_W{1'b0}}, pcw};

    generate
        if (FRAC_W > 0) begin : g_frac
            assign vco = (prod >> FRAC_W) + RATE_W'(|prod[FRAC_W-1:0]);
        end else begin : g_int
            assign vco = prod;
        end
    endgenerate

    assign biased = {1'b0, vco} + (((RATE_W+1)'(1)) << exp_i) - (RATE_W+1)'(1);
    assign rate_o = RATE_W'(biased >> exp_i);

endmodule

// File: rtl/pll_rate_calc.sv
module pll_rate_calc
    import pll_rate_calc_pkg::*;
#(
    parameter int              FREQ_W  = 32,
    parameter int              PCW_W   = 22,
    parameter longint unsigned FMIN_HZ = 64'd1_000_000_000
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      in_valid,
    output logic                      in_ready,
    input  logic                      in_op,
    input  logic [FREQ_W-1:0]         in_target_hz,
    input  logic [FREQ_W-1:0]         in_fmax_hz,
    input  logic [FREQ_W-1:0]         in_ref_hz,
    input  logic [PCW_W-1:0]          in_pcw,
    input  logic [2:0]                in_pdiv_exp,
    output logic                      done,
    output logic                      err,
    output logic [PCW_W-1:0]          out_pcw,
    output logic [2:0]                out_pdiv_exp,
    output logic [FREQ_W+PCW_W-1:0]   out_rate_hz
);
    localparam int FRAC_W = frac_bits(PCW_W);
    localparam int NUM_W  = FREQ_W + 3 + FRAC_W;
    localparam int RATE_W = FREQ_W + PCW_W;

    typedef struct packed {
        calc_state_e       st;
        logic [FREQ_W-1:0] tgt;
        logic [FREQ_W-1:0] refclk;
        logic [PCW_W-1:0]  pcw;
        logic [EXP_W-1:0]  pexp;
        logic              done;
        logic              err;
        logic [PCW_W-1:0]  res_pcw;
        logic [EXP_W-1:0]  res_exp;
        logic [RATE_W-1:0] res_rate;
    } calc_regs_t;

    calc_regs_t q, d;

    logic [EXP_W-1:0]  fwd_exp;
    logic [NUM_W-1:0]  div_num;
    logic              div_start;
    logic              div_done;
    logic [PCW_W-1:0]  div_quot;
    logic [RATE_W-1:0] rev_rate;

    pll_pdiv_search #(
        .FREQ_W  (FREQ_W),
        .FMIN_HZ (FMIN_HZ)
    ) u_search (
        .freq_hz (q.tgt),
        .exp_o   (fwd_exp)
    );

    // Scaled numerator: target << post-divider exponent << fractional bits
    assign div_num   = (NUM_W'(q.tgt) << fwd_exp) << FRAC_W;
    assign div_start = (q.st == CALC_FWD) && (q.refclk != '0);

    pll_seq_divider #(
        .NUM_W (NUM_W),
        .DEN_W (FREQ_W),
        .OUT_W (PCW_W)
    ) u_div (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (div_start),
        .num    (div_num),
        .den    (q.refclk),
        .done_o (div_done),
        .quot_o (div_quot)
    );

    pll_rate_recalc #(
        .FREQ_W (FREQ_W),
        .PCW_W  (PCW_W)
    ) u_recalc (
        .ref_hz (q.refclk),
        .pcw    (q.pcw),
        .exp_i  (q.pexp),
        .rate_o (rev_rate)
    );

    always_comb begin
        d      = q;
        d.done = 1'b0;
        unique case (q.st)
            CALC_IDLE: begin
                if (in_valid) begin
                    d.tgt    = (in_target_hz > in_fmax_hz) ? in_fmax_hz : in_target_hz;
                    d.refclk = in_ref_hz;
                    d.pcw    = in_pcw;
                    d.pexp   = in_pdiv_exp;
                    d.st     = in_op ? CALC_REV : CALC_FWD;
                end
            end
            CALC_REV: begin
                d.res_rate = rev_rate;
                d.res_pcw  = '0;
                d.res_exp  = '0;
                d.err      = 1'b0;
                d.done     = 1'b1;
                d.st       = CALC_IDLE;
            end
            CALC_FWD: begin
                if (q.refclk == '0) begin
                    d.res_pcw  = '0;
                    d.res_exp  = fwd_exp;
                    d.res_rate = '0;
                    d.err      = 1'b1;
                    d.done     = 1'b1;
                    d.st       = CALC_IDLE;
                end else begin
                    d.st = CALC_WAIT;
                end
            end
            CALC_WAIT: begin
                if (div_done) begin
                    d.res_pcw  = div_quot;
                    d.res_exp  = fwd_exp;
                    d.res_rate = '0;
                    d.err      = 1'b0;
                    d.done     = 1'b1;
                    d.st       = CALC_IDLE;
                end
            end
            default: d.st = CALC_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign in_ready     = (q.st == CALC_IDLE);
    assign done         = q.done;
    assign err          = q.err;
    assign out_pcw      = q.res_pcw;
    assign out_pdiv_exp = q.res_exp;
    assign out_rate_hz  = q.res_rate;

endmodule

// File: rtl/pll_rate_calc_chk.sv
module pll_rate_calc_chk #(
    parameter int FREQ_W = 32,
    parameter int PCW_W  = 22
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    in_valid,
    input logic                    in_ready,
    input logic                    done,
    input logic                    err,
    input logic [PCW_W-1:0]        out_pcw,
    input logic [2:0]              out_pdiv_exp,
    input logic [FREQ_W+PCW_W-1:0] out_rate_hz
);
    // R8: an accepted request makes the block busy on the next cycle
    a_r8_accept_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> !in_ready);

    // R8: completion is a single-cycle pulse
    a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R8: the block is idle again when it signals completion
    a_r8_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> in_ready);

    // R7: an error result carries a zero control word and zero rate
    a_r7_err_zero: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> (out_pcw == '0 && out_rate_hz == '0));

    // R10: results move only with done
    a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> ($stable(out_pcw) && $stable(out_rate_hz)
                   && $stable(out_pdiv_exp) && $stable(err)));

    // R3: exponent never exceeds the largest factor tried
    a_r3_exp_bound: assert property (@(posedge clk) disable iff (!rst_n)
        out_pdiv_exp <= 3'd3);

endmodule

bind pll_rate_calc pll_rate_calc_chk #(
    .FREQ_W (FREQ_W),
    .PCW_W  (PCW_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .in_valid     (in_valid),
    .in_ready     (in_ready),
    .done         (done),
    .err          (err),
    .out_pcw      (out_pcw),
    .out_pdiv_exp (out_pdiv_exp),
    .out_rate_hz  (out_rate_hz)
);

// File: tb/test_pll_rate_calc.sv
`timescale 1ns/1ps
module test_pll_rate_calc;
    localparam int PW_A = 10;
    localparam int FR_A = 3;
    localparam int PW_B = 7;
    localparam int FR_B = 0;
    localparam longint unsigned FMIN = 64'd1_000_000_000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_op = 1'b0;
    logic [31:0] in_target_hz = '0;
    logic [31:0] in_fmax_hz = '0;
    logic [31:0] in_ref_hz = '0;
    logic [9:0]  in_pcw = '0;
    logic [2:0]  in_pdiv_exp = '0;

    logic        rdy_a, done_a, err_a;
    logic [9:0]  pcw_a;
    logic [2:0]  exp_a;
    logic [41:0] rate_a;
    logic        rdy_b, done_b, err_b;
    logic [6:0]  pcw_b;
    logic [2:0]  exp_b;
    logic [38:0] rate_b;

    int n_checks = 0;
    int n_errs   = 0;

    always #2.5 clk = ~clk;

    pll_rate_calc #(.FREQ_W(32), .PCW_W(PW_A), .FMIN_HZ(FMIN)) i_pll_rate_calc (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(rdy_a),
        .in_op(in_op), .in_target_hz(in_target_hz), .in_fmax_hz(in_fmax_hz),
        .in_ref_hz(in_ref_hz), .in_pcw(in_pcw), .in_pdiv_exp(in_pdiv_exp),
        .done(done_a), .err(err_a), .out_pcw(pcw_a), .out_pdiv_exp(exp_a),
        .out_rate_hz(rate_a));

    pll_rate_calc #(.FREQ_W(32), .PCW_W(PW_B), .FMIN_HZ(FMIN)) i_pll_rate_calc_int (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(rdy_b),
        .in_op(in_op), .in_target_hz(in_target_hz), .in_fmax_hz(in_fmax_hz),
        .in_ref_hz(in_ref_hz), .in_pcw(in_pcw[6:0]), .in_pdiv_exp(in_pdiv_exp),
        .done(done_b), .err(err_b), .out_pcw(pcw_b), .out_pdiv_exp(exp_b),
        .out_rate_hz(rate_b));

    task automatic check(input string req, input string what,
                         input logic [63:0] act, input logic [63:0] expv);
        n_checks++;
        if (act !== expv) begin
            n_errs++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, expv);
        end
    endtask

    task automatic finish_run();
        $display("  Result: errors=%0d of %0d checks", n_errs, n_checks);
        $finish;
    endtask

    function automatic logic [63:0] m_exp(input logic [31:0] f);
        for (int k = 0; k < 4; k++) begin
            if ((64'(f) << k) >= FMIN) return 64'(k);
        end
        return 64'd3;
    endfunction

    function automatic logic [63:0] m_pcw(input logic [31:0] f, input logic [31:0] rf,
                                          input int frac, input int w);
        logic [63:0] num;
        if (rf == 0) return 64'd0;
        num = (64'(f) << m_exp(f)) << frac;
        return (num / 64'(rf)) & ((64'd1 << w) - 64'd1);
    endfunction

    function automatic logic [63:0] m_rate(input logic [31:0] rf, input logic [63:0] pcw,
                                           input int frac, input int e);
        logic [63:0] prod, vco;
        prod = 64'(rf) * pcw;
        if (frac > 0 && (prod & ((64'd1 << frac) - 64'd1)) != 0) vco = (prod >> frac) + 64'd1;
        else vco = prod >> frac;
        return (vco + (64'd1 << e) - 64'd1) >> e;
    endfunction

    logic [63:0] ga_pcw, ga_exp, ga_rate, ga_err, gb_pcw, gb_exp, gb_rate, gb_err;

    task automatic run_req(input logic op, input logic [31:0] tgt, input logic [31:0] fmax,
                           input logic [31:0] rf, input logic [9:0] pcw, input logic [2:0] e);
        bit got_a, got_b;
        int cyc;
        @(negedge clk);
        in_op = op; in_target_hz = tgt; in_fmax_hz = fmax; in_ref_hz = rf;
        in_pcw = pcw; in_pdiv_exp = e; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        got_a = 0; got_b = 0; cyc = 0;
        while (!(got_a && got_b) && cyc < 300) begin
            if (done_a) begin
                got_a = 1; ga_pcw = 64'(pcw_a); ga_exp = 64'(exp_a);
                ga_rate = 64'(rate_a); ga_err = 64'(err_a);
            end
            if (done_b) begin
                got_b = 1; gb_pcw = 64'(pcw_b); gb_exp = 64'(exp_b);
                gb_rate = 64'(rate_b); gb_err = 64'(err_b);
            end
            @(negedge clk);
            cyc++;
        end
        check("R8", "done seen (fractional instance)", 64'(got_a), 64'd1);
        check("R8", "done seen (integer instance)", 64'(got_b), 64'd1);
    endtask

    task automatic fwd_case(input logic [31:0] tgt, input logic [31:0] fmax, input logic [31:0] rf);
        logic [31:0] f;
        f = (tgt > fmax) ? fmax : tgt;
        run_req(1'b0, tgt, fmax, rf, 10'd0, 3'd0);
        if (tgt > fmax) check("R2", "clamped pcw", ga_pcw, m_pcw(f, rf, FR_A, PW_A));
        else            check("R4", "fwd pcw", ga_pcw, m_pcw(f, rf, FR_A, PW_A));
        check("R3", "fwd exp", ga_exp, m_exp(f));
        check("R4", "fwd rate zero", ga_rate, 64'd0);
        check("R7", "fwd err", ga_err, (rf == 0) ? 64'd1 : 64'd0);
        check("R1", "int-only pcw", gb_pcw, m_pcw(f, rf, FR_B, PW_B));
        check("R1", "int-only exp", gb_exp, m_exp(f));
    endtask

    task automatic rev_case(input logic [31:0] rf, input logic [9:0] pcw, input logic [2:0] e);
        run_req(1'b1, 32'd0, 32'd0, rf, pcw, e);
        check("R5 R6", "rev rate", ga_rate, m_rate(rf, 64'(pcw), FR_A, int'(e)));
        check("R5", "rev pcw zero", ga_pcw, 64'd0);
        check("R5", "rev exp zero", ga_exp, 64'd0);
        check("R7", "rev err", ga_err, 64'd0);
        check("R1", "int-only rate", gb_rate, m_rate(rf, 64'(pcw[6:0]), FR_B, int'(e)));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_errs++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        finish_run();
    end

    initial begin
        logic [31:0] tgts [12];
        logic [31:0] fmaxs [2];
        logic [31:0] refs [5];
        int pulses;
        logic [63:0] hold_pcw, hold_exp;
        tgts = '{32'd1, 32'd100_000_000, 32'd124_999_999, 32'd125_000_000,
                 32'd249_999_999, 32'd250_000_000, 32'd499_999_999, 32'd500_000_000,
                 32'd999_999_999, 32'd1_000_000_000, 32'd1_500_000_000, 32'hFFFF_FFFF};
        fmaxs = '{32'hFFFF_FFFF, 32'd600_000_000};
        refs = '{32'd26_000_000, 32'd25_000_000, 32'd3_000_000, 32'd1, 32'd0};

        repeat (3) @(negedge clk);
        // R9: reset values
        check("R9", "ready in reset", 64'(rdy_a), 64'd1);
        check("R9", "done in reset", 64'(done_a), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R9", "ready after reset", 64'(rdy_a), 64'd1);
        check("R9", "err after reset", 64'(err_a), 64'd0);
        check("R9", "pcw after reset", 64'(pcw_a), 64'd0);
        check("R9", "rate after reset", 64'(rate_a), 64'd0);
        check("R9", "exp after reset", 64'(exp_a), 64'd0);

        for (int ti = 0; ti < 12; ti++)
            for (int fi = 0; fi < 2; fi++)
                for (int ri = 0; ri < 5; ri++)
                    fwd_case(tgts[ti], fmaxs[fi], refs[ri]);

        for (int ri = 0; ri < 4; ri++)
            for (int p = 0; p < 1024; p += 31)
                for (int e = 0; e < 8; e++)
                    rev_case(refs[ri], 10'(p), 3'(e));
        for (int e = 0; e < 8; e++) rev_case(32'hFFFF_FFFF, 10'h3FF, 3'(e));

        // R8 / R10: strobe while a forward division is busy; it must be ignored
        @(negedge clk);
        in_op = 1'b0; in_target_hz = 32'd300_000_000; in_fmax_hz = 32'hFFFF_FFFF;
        in_ref_hz = 32'd26_000_000; in_pcw = '0; in_pdiv_exp = '0; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        check("R8", "busy after accept", 64'(rdy_a), 64'd0);
        repeat (4) @(negedge clk);
        in_op = 1'b1; in_ref_hz = 32'd1; in_pcw = 10'h3FF; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        pulses = 0;
        for (int c = 0; c < 120; c++) begin
            if (done_a) pulses++;
            @(negedge clk);
        end
        check("R8", "one done for one request", 64'(pulses), 64'd1);
        check("R8", "busy strobe ignored pcw", 64'(pcw_a),
              m_pcw(32'd300_000_000, 32'd26_000_000, FR_A, PW_A));
        check("R8", "busy strobe ignored rate", 64'(rate_a), 64'd0);
        hold_pcw = 64'(pcw_a);
        hold_exp = 64'(exp_a);
        check("R3", "exp for 300 MHz", hold_exp, 64'd2);
        repeat (10) @(negedge clk);
        check("R10", "pcw held idle", 64'(pcw_a), hold_pcw);
        check("R10", "exp held idle", 64'(exp_a), hold_exp);

        finish_run();
    end

endmodule